// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block watches one external non-maskable interrupt line and turns it into an interrupt request for a parent controller. A two-bit sense field picks whether the line is read as an active-low level, an active-high level, a falling edge or a rising edge. Each qualifying event sets a sticky pending flag, software clears the flag by writing a one, and an enable bit gates the pending flag onto the request output.

Software reaches the three registers over a plain synchronous read/write bus. An elaboration parameter picks one of four address arrangements, so the same block drops into address maps that place the registers differently. The raw line is synchronized before any detection, so it may come from an unrelated clock domain.

Top module: `nmi_trigger_ctrl`

## Requirements
- R1: While reset is asserted `irq_req` is 0 and `bus_rdata` is 0. After reset the sense field and the enable bit read back as 0 (masked, active-low level).
- R2: The line passes through two synchronizing flops. A level first sampled on `nmi_in` at rising edge k reaches the detector so that pending is set at edge k+2 at the earliest, and not before.
- R3: Sense field bits [1:0] of the control register: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge.
- R4: In the two level encodings pending is set on every cycle the synchronized line is at its active level, so a clear has no lasting effect while the line stays active. In the two edge encodings pending is set only on a qualifying transition of the synchronized line.
- R5: `irq_req` is the pending bit AND the enable bit, where the enable bit is bit 0 of the enable register (1 = unmasked). Masking does not clear pending.
- R6: Pending is bit 0 of the pending register. A write with data bit 0 = 1 clears it; a write with data bit 0 = 0 leaves it unchanged. When a detected event and a clearing write fall in the same cycle, pending stays set.
- R7: A write to the control register changes only bits [1:0]; bits above them hold their reset value of 0 and read back as 0.
- R8: Parameter `LAYOUT` picks byte offsets (control, pending, enable): 0 gives (0x00, 0x04, 0x08); 1 gives (0x00, 0x08, 0x04); 2 gives (0x0C, 0x10, 0x40); 3 gives (0x00, 0x04, 0x34).
- R9: A read (`bus_sel` = 1, `bus_wr` = 0) returns the addressed register on `bus_rdata` one cycle later, with unused bits 0. A read of an offset not used by the selected layout returns 0, and `bus_rdata` is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Raw interrupt line, asynchronous |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_req | output | 1 | Request to the parent interrupt controller |

## Verification
The hardest situation to reach from the ports is a clearing write landing in the same cycle as a detected event, because the event happens two synchronizer stages after the line moves. The stimulus gets there by holding the line at its active level in a level encoding and then clearing, so every cycle carries an event and the clear must lose. The edge encodings are taken the other way: the line is held steady after its transition, a clear is issued, and pending must stay low. All four layouts are instantiated side by side with a shared bus, so one address sequence shows which offsets each layout decodes and which it ignores.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

   typedef enum logic [1:0] {
      SENSE_LVL_LOW  = 2'd0,
      SENSE_FALL     = 2'd1,
      SENSE_LVL_HIGH = 2'd2,
      SENSE_RISE     = 2'd3
   } sense_mode_e;

   localparam int NUM_LAYOUTS = 4;

   // Byte offsets of the control register per layout.
   function automatic int ctl_offset(input int layout);
      case (layout)
         2:       return 'h0C;
         default: return 'h00;
      endcase
   endfunction

   // Byte offsets of the pending register per layout.
   function automatic int pend_offset(input int layout);
      case (layout)
         1:       return 'h08;
         2:       return 'h10;
         default: return 'h04;
      endcase
   endfunction

   // Byte offsets of the enable register per layout.
   function automatic int en_offset(input int layout);
      case (layout)
         1:       return 'h04;
         2:       return 'h40;
         3:       return 'h34;
         default: return 'h08;
      endcase
   endfunction

   // Highest offset a layout uses, for the address width check.
   function automatic int max_offset(input int layout);
      int m;
      m = ctl_offset(layout);
      if (pend_offset(layout) > m) m = pend_offset(layout);
      if (en_offset(layout) > m) m = en_offset(layout);
      return m;
   endfunction

endpackage

// File: rtl/nmi_sync_chain.sv
module nmi_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] stg_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= 1'b0;
            else        stg_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= 1'b0;
            else        stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/nmi_sense_detect.sv
module nmi_sense_detect
   import nmi_trig_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        line_sync,
   input  sense_mode_e mode,
   output logic        event_hit
);
   logic line_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev_q <= 1'b0;
      else        line_prev_q <= line_sync;
   end

   always_comb begin
      unique case (mode)
         SENSE_LVL_LOW:  event_hit = !line_sync;
         SENSE_FALL:     event_hit = line_prev_q && !line_sync;
         SENSE_LVL_HIGH: event_hit = line_sync;
         SENSE_RISE:     event_hit = !line_prev_q && line_sync;
         default:        event_hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/nmi_trig_regs.sv
module nmi_trig_regs
   import nmi_trig_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LAYOUT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              event_hit,
   output sense_mode_e       mode,
   output logic              pend,
   output logic              enable
);
   localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(ctl_offset(LAYOUT));
   localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(pend_offset(LAYOUT));
   localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(en_offset(LAYOUT));

   sense_mode_e       mode_q;
   logic              pend_q;
   logic              en_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic              hit_ctl, hit_pend, hit_en;
   logic              wr_cyc, rd_cyc, clr_pend;
   logic [1:0]        mode_bits;

   assign hit_ctl  = (bus_addr == OFF_CTL);
   assign hit_pend = (bus_addr == OFF_PEND);
   assign hit_en   = (bus_addr == OFF_EN);
   assign wr_cyc   = bus_sel && bus_wr;
   assign rd_cyc   = bus_sel && !bus_wr;
   assign clr_pend = wr_cyc && hit_pend && bus_wdata[0];
   assign mode_bits = mode_q;

   always_comb begin
      rd_mux = '0;
      if (hit_ctl)       rd_mux = DATA_W'(mode_bits);
      else if (hit_pend) rd_mux = DATA_W'(pend_q);
      else if (hit_en)   rd_mux = DATA_W'(en_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= SENSE_LVL_LOW;
         pend_q  <= 1'b0;
         en_q    <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (wr_cyc && hit_ctl) mode_q <= sense_mode_e'(bus_wdata[1:0]);
         if (wr_cyc && hit_en)  en_q   <= bus_wdata[0];
         pend_q  <= event_hit || (pend_q && !clr_pend);
         rdata_q <= rd_cyc ? rd_mux : '0;
      end
   end

   assign mode      = mode_q;
   assign pend      = pend_q;
   assign enable    = en_q;
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/nmi_trigger_ctrl.sv
module nmi_trigger_ctrl
   import nmi_trig_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int LAYOUT      = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req
);
   if (LAYOUT < 0 || LAYOUT >= NUM_LAYOUTS) begin : g_bad_layout
      $error("nmi_trigger_ctrl: LAYOUT out of range");
   end
   if ((1 << ADDR_W) <= max_offset(LAYOUT)) begin : g_bad_addr
      $error("nmi_trigger_ctrl: ADDR_W too narrow for the chosen layout");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("nmi_trigger_ctrl: DATA_W must hold the sense field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nmi_trigger_ctrl: at least two synchronizer stages needed");
   end

   logic        line_sync;
   logic        event_hit;
   sense_mode_e mode;
   logic        pend;
   logic        enable;

   nmi_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (nmi_in),
      .q_sync  (line_sync)
   );

   nmi_sense_detect u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_sync (line_sync),
      .mode      (mode),
      .event_hit (event_hit)
   );

   nmi_trig_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LAYOUT (LAYOUT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .event_hit (event_hit),
      .mode      (mode),
      .pend      (pend),
      .enable    (enable)
   );

   assign irq_req = pend && enable;
endmodule

// File: rtl/nmi_trigger_ctrl_chk.sv
module nmi_trigger_ctrl_chk
   import nmi_trig_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int LAYOUT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_req,
   input logic              event_hit,
   input logic              pend,
   input logic [1:0]        mode_bits
);
   logic a_ctl, a_pend, a_any, a_clr, a_rd;
   assign a_ctl  = (bus_addr == ADDR_W'(ctl_offset(LAYOUT)));
   assign a_pend = (bus_addr == ADDR_W'(pend_offset(LAYOUT)));
   assign a_any  = a_ctl || a_pend || (bus_addr == ADDR_W'(en_offset(LAYOUT)));
   assign a_rd   = bus_sel && !bus_wr;
   assign a_clr  = bus_sel && bus_wr && a_pend && bus_wdata[0];

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_req && bus_rdata == '0));

   p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (event_hit && mode_bits[0]) |=> !(event_hit && $stable(mode_bits)));

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      event_hit |=> pend);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_clr && !event_hit) |=> !pend);

   p_ctl_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && a_ctl) |=> (bus_rdata[DATA_W-1:2] == '0));

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd && !a_any) |=> (bus_rdata == '0));

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !a_rd |=> (bus_rdata == '0));
endmodule

bind nmi_trigger_ctrl nmi_trigger_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LAYOUT (LAYOUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_req   (irq_req),
   .event_hit (event_hit),
   .pend      (pend),
   .mode_bits (u_regs.mode_bits)
);

// File: tb/tb_nmi_trigger_ctrl.sv
module tb_nmi_trigger_ctrl;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_in = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] rd_w [4];
   logic          irq_w [4];

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   logic [DW-1:0] got [4];

   always #10 clk = ~clk;

   nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(0)) dut (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[0]), .irq_req(irq_w[0]));
   nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(1)) dut_l1 (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[1]), .irq_req(irq_w[1]));
   nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(2)) dut_l2 (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[2]), .irq_req(irq_w[2]));
   nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(3)) dut_l3 (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w[3]), .irq_req(irq_w[3]));

   // Offsets per layout, written from R8.
   function automatic int m_ctl(int l);
      return (l == 2) ? 'h0C : 'h00;
   endfunction
   function automatic int m_pnd(int l);
      return (l == 1) ? 'h08 : (l == 2) ? 'h10 : 'h04;
   endfunction
   function automatic int m_enb(int l);
      return (l == 1) ? 'h04 : (l == 2) ? 'h40 : (l == 3) ? 'h34 : 'h08;
   endfunction

   // Reference model: one state set per layout, shared input history.
   int m_mode [4];
   int m_en   [4];
   int m_pend [4];
   logic [DW-1:0] m_rd [4];
   int hist [$];

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         for (int l = 0; l < 4; l++) begin
            m_mode[l] = 0; m_en[l] = 0; m_pend[l] = 0; m_rd[l] = '0;
         end
         hist = {0, 0, 0};
      end else begin
         int cur, prv;
         cur = hist[1];
         prv = hist[2];
         for (int l = 0; l < 4; l++) begin
            int ev, a, clr;
            logic [DW-1:0] nrd;
            a = int'(bus_addr);
            case (m_mode[l])
               0: ev = (cur == 0);
               1: ev = (prv == 1 && cur == 0);
               2: ev = (cur == 1);
               default: ev = (prv == 0 && cur == 1);
            endcase
            nrd = '0;
            if (bus_sel && !bus_wr) begin
               if (a == m_ctl(l))      nrd = DW'(m_mode[l]);
               else if (a == m_pnd(l)) nrd = DW'(m_pend[l]);
               else if (a == m_enb(l)) nrd = DW'(m_en[l]);
            end
            clr = (bus_sel && bus_wr && a == m_pnd(l) && bus_wdata[0]);
            if (bus_sel && bus_wr && a == m_ctl(l)) m_mode[l] = int'(bus_wdata[1:0]);
            if (bus_sel && bus_wr && a == m_enb(l)) m_en[l] = int'(bus_wdata[0]);
            if (ev) m_pend[l] = 1;
            else if (clr) m_pend[l] = 0;
            m_rd[l] = nrd;
         end
         hist.push_front(int'(nmi_in));
         if (hist.size() > 3) void'(hist.pop_back());
      end
   end

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Every-clock comparison against the model.
   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < 4; l++) begin
            logic exp_irq;
            exp_irq = (m_pend[l] != 0) && (m_en[l] != 0);
            check(irq_w[l] == exp_irq, $sformatf("R5 layout %0d irq_req", l),
                  DW'(irq_w[l]), DW'(exp_irq));
            check(rd_w[l] == m_rd[l], $sformatf("R9 layout %0d bus_rdata", l),
                  rd_w[l], m_rd[l]);
         end
      end
   end

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
         finish_up();
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      for (int l = 0; l < 4; l++) got[l] = rd_w[l];
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R1: quiet outputs in reset
      repeat (3) begin
         @(negedge clk);
         for (int l = 0; l < 4; l++) begin
            check(irq_w[l] == 1'b0, "R1 irq in reset", DW'(irq_w[l]), '0);
            check(rd_w[l] == '0, "R1 rdata in reset", rd_w[l], '0);
         end
      end
      rst_n = 1'b1;
      rd('h00); check(got[0] == 0, "R1 sense field after reset", got[0], 0);
      rd('h08); check(got[0] == 0, "R1 enable after reset", got[0], 0);

      // R7: only the sense field is writable
      wr('h00, 32'hFFFF_FFFE);
      rd('h00); check(got[0] == 32'h2, "R7 control readback", got[0], 32'h2);

      // R6/R4: active-high level held, clear loses to the event
      wr('h04, 32'h1);
      rd('h04); check(got[0] == 1, "R6 set wins over clear (R4 level)", got[0], 1);

      // R6: clear once the line is inactive
      nmi_in = 1'b0;
      idle(4);
      wr('h04, 32'h1);
      rd('h04); check(got[0] == 0, "R6 write-one clear", got[0], 0);

      // R5: enabled but nothing pending
      wr('h08, 32'h1);
      check(irq_w[0] == 1'b0, "R5 enabled, not pending", DW'(irq_w[0]), 0);

      // R2/R3: rising edge through the synchronizer
      wr('h00, 32'h3);
      idle(2);
      nmi_in = 1'b1;
      @(negedge clk); check(irq_w[0] == 1'b0, "R2 edge k", DW'(irq_w[0]), 0);
      @(negedge clk); check(irq_w[0] == 1'b0, "R2 edge k+1", DW'(irq_w[0]), 0);
      @(negedge clk); check(irq_w[0] == 1'b1, "R2 R3 rise at edge k+2", DW'(irq_w[0]), 1);

      // R4: edge mode does not re-set while the line stays high
      wr('h04, 32'h1);
      idle(3);
      rd('h04); check(got[0] == 0, "R4 edge no re-set", got[0], 0);

      // R3: falling edge
      wr('h00, 32'h1);
      nmi_in = 1'b0;
      idle(4);
      check(irq_w[0] == 1'b1, "R3 fall", DW'(irq_w[0]), 1);

      // R6: writing zero leaves pending set
      wr('h04, 32'hFFFF_FFFE);
      rd('h04); check(got[0] == 1, "R6 write zero ignored", got[0], 1);

      // R5: masking hides the request, pending stays
      wr('h08, 32'h0);
      check(irq_w[0] == 1'b0, "R5 masked", DW'(irq_w[0]), 0);
      rd('h04); check(got[0] == 1, "R5 pending kept when masked", got[0], 1);
      wr('h04, 32'h1);
      rd('h04); check(got[0] == 0, "R6 clear edge pending", got[0], 0);

      // R3/R4: active-low level held
      wr('h00, 32'h0);
      idle(3);
      wr('h04, 32'h1);
      rd('h04); check(got[0] == 1, "R3 R4 low level re-sets", got[0], 1);
      nmi_in = 1'b1;
      idle(3);
      wr('h04, 32'h1);
      rd('h04); check(got[0] == 0, "R3 low level released", got[0], 0);

      // R9: unmapped offsets
      rd('h0C); check(got[0] == 0, "R9 unmapped 0x0C", got[0], 0);
      rd('h40); check(got[0] == 0, "R9 unmapped 0x40", got[0], 0);

      // R8: layout-specific offsets
      wr('h40, 32'h1);
      rd('h40);
      check(got[2] == 1, "R8 layout 2 enable at 0x40", got[2], 1);
      check(got[0] == 0, "R8 layout 0 ignores 0x40", got[0], 0);
      wr('h34, 32'h1);
      rd('h34);
      check(got[3] == 1, "R8 layout 3 enable at 0x34", got[3], 1);
      check(got[2] == 0, "R8 layout 2 ignores 0x34", got[2], 0);
      wr('h04, 32'h1);
      rd('h04);
      check(got[1] == 1, "R8 layout 1 enable at 0x04", got[1], 1);
      wr('h0C, 32'h2);
      rd('h0C);
      check(got[2] == 2, "R8 layout 2 control at 0x0C", got[2], 2);
      check(got[0] == 0, "R8 layout 0 ignores 0x0C", got[0], 0);

      // R9: no read, rdata zero
      @(negedge clk);
      check(rd_w[0] == '0, "R9 idle rdata", rd_w[0], '0);

      idle(2);
      finish_up();
   end
endmodule